// File: doc/BRIEF.md
# Scanline Memory-Slot Scheduler

This block decides, for every memory-access slot of a video scanline, which requester owns the shared memory bus. The beam timing logic presents the slot number of the current cycle. The scheduler returns a registered one-hot grant one cycle later. The requesters are the floppy transfer engine, the four sound channels, the eight hardware sprites, the bitplane fetcher, the display-list coprocessor and the CPU. For bitplane slots the block also returns the plane the word belongs to.

The start of each line is reserved for the fixed consumers: three floppy slots, four sound slots and sixteen sprite slots. The bitplane window follows directly. Its length comes from the display configuration, which is resolution, requested plane count and fetch width. The scheduler latches that configuration once per line, when the slot number is zero. A request that cannot fit the per-line bitplane budget is reduced to the largest plane count that fits, and a status flag is raised. Every slot past the bitplane window goes first to the coprocessor, then to the CPU, and otherwise stays idle.

Top module: `dma_slot_sched`

## Requirements
- R1: While `rst_n` is low, `grant`, `plane_idx`, `eff_planes` and `clamped` are all zero.
- R2: A slot number 0 to 2 grants the floppy requester, `grant` = 6'b000001, whatever the coprocessor and CPU requests are.
- R3: Slot numbers 3 to 6 grant sound (6'b000010) and 7 to 22 grant sprites (6'b000100), whatever the requests are.
- R4: The bitplane window starts at slot 23 and lasts N = ceil(P × W / F) slots, granting 6'b001000 even if the coprocessor requests. P is the effective plane count. W is the words per plane: 8, 20 or 40 for `cfg_res` 0 (low), 1 (high), or 2 and 3 (super-high). F is the fetch width in words. With P = 0 the window is empty.
- R5: During a bitplane grant, `plane_idx` = (slot − 23) mod P, so the planes take turns slot by slot. Outside bitplane grants `plane_idx` is 0.
- R6: `cfg_fetch` code 0 gives 1 word per slot, code 1 gives 2 words and code 3 gives 4 words. The reserved code 2 behaves as code 0.
- R7: P = min(requested, 8, floor(80 × F / W)), where 80 is the bitplane slot budget. `clamped` is 1 exactly when P is less than the request. Examples: high resolution at code 0 allows 4 planes, and super-high resolution at code 0 allows 2.
- R8: The configuration inputs are sampled only on a cycle where `slot_idx` = 0. At any other slot, changes have no effect on the window, `eff_planes` or `clamped` until the next slot 0.
- R9: A slot that is neither fixed nor in the bitplane window grants the coprocessor (6'b010000) if `copr_req` is 1. Otherwise it grants the CPU (6'b100000) if `cpu_req` is 1. Otherwise `grant` is 0.
- R10: A slot number of 228 or above grants nothing.
- R11: `grant` holds at most one set bit and reflects the slot presented on the previous clock edge. It does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_idx | input | 8 | Slot number within the line from beam timing |
| cfg_res | input | 2 | Resolution code: 0 low, 1 high, 2 or 3 super-high |
| cfg_planes | input | 4 | Requested bitplane count |
| cfg_fetch | input | 2 | Fetch width code (0, 1, 3; 2 acts as 0) |
| copr_req | input | 1 | Coprocessor wants a slot |
| cpu_req | input | 1 | CPU wants a slot |
| grant | output | 6 | One-hot owner: bit0 floppy, bit1 sound, bit2 sprite, bit3 bitplane, bit4 coprocessor, bit5 CPU |
| plane_idx | output | 3 | Plane of the current bitplane grant |
| eff_planes | output | 4 | Plane count in force for this line after limiting |
| clamped | output | 1 | Request for this line exceeded the legal plane count |

## Verification
The bench probes both edges of each region: the last sprite slot, the first and last bitplane slot, and the first slot after the window. An off-by-one in the window length would hand the last plane word to the CPU, or steal a free slot. Clamping is driven at high and super-high resolution, with a request above the plane ceiling, and at every fetch code including the reserved one. A wrong limit shows up as a wrong window length or a wrong plane rotation. The bench also changes the configuration in mid-line and then presents a slot numbered past the end of the line. A design that samples the configuration continuously would move the window before the next line, and one without a range guard would grant past the end of the line.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  // Slot owner codes; grant bit k corresponds to code k+1
  typedef enum logic [2:0] {
    OWN_NONE   = 3'd0,
    OWN_DISK   = 3'd1,
    OWN_AUDIO  = 3'd2,
    OWN_SPRITE = 3'd3,
    OWN_BPL    = 3'd4,
    OWN_COPR   = 3'd5,
    OWN_CPU    = 3'd6
  } owner_e;

  localparam int unsigned NUM_REQ = 6;

  // Words moved per slot for a fetch width code
  function automatic int unsigned fetch_words(input logic [1:0] code);
    case (code)
      2'd1:    return 2;
      2'd3:    return 4;
      default: return 1;
    endcase
  endfunction

  // Words of one plane per line for a resolution code
  function automatic int unsigned words_per_plane(input logic [1:0] res,
                                                  input int unsigned lo,
                                                  input int unsigned hi,
                                                  input int unsigned shi);
    case (res)
      2'd0:    return lo;
      2'd1:    return hi;
      default: return shi;
    endcase
  endfunction

  // Largest plane count whose slots fit the budget
  function automatic int unsigned plane_limit(input int unsigned budget,
                                              input int unsigned wpp,
                                              input int unsigned fw,
                                              input int unsigned maxp);
    int unsigned fit;
    fit = (budget * fw) / wpp;
    return (fit < maxp) ? fit : maxp;
  endfunction

  // Bitplane slots for a plane count, rounded up
  function automatic int unsigned slots_needed(input int unsigned planes,
                                               input int unsigned wpp,
                                               input int unsigned fw);
    return (planes * wpp + fw - 1) / fw;
  endfunction

  // Plane served at a given offset in the window
  function automatic int unsigned plane_of(input int unsigned offset,
                                           input int unsigned planes);
    return (planes == 0) ? 0 : offset % planes;
  endfunction

endpackage

// File: rtl/dma_cfg_latch.sv
module dma_cfg_latch
  import dma_sched_pkg::*;
#(
  parameter int unsigned REQ_W      = 4,
  parameter int unsigned PL_W       = 4,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned MAX_PLANES = 8,
  parameter int unsigned BPL_BUDGET = 80,
  parameter int unsigned LO_WPP     = 8,
  parameter int unsigned HI_WPP     = 20,
  parameter int unsigned SHI_WPP    = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       res,
  input  logic [REQ_W-1:0] planes_req,
  input  logic [1:0]       fetch,
  output logic [PL_W-1:0]  eff_planes,
  output logic [LEN_W-1:0] bpl_len,
  output logic             clamped
);

  int unsigned wpp;
  int unsigned fw;
  int unsigned limit;
  int unsigned req;
  int unsigned next_eff;
  int unsigned next_len;
  logic        next_clamp;

  always_comb begin
    wpp        = words_per_plane(res, LO_WPP, HI_WPP, SHI_WPP);
    fw         = fetch_words(fetch);
    limit      = plane_limit(BPL_BUDGET, wpp, fw, MAX_PLANES);
    req        = 32'(planes_req);
    next_clamp = (req > limit);
    next_eff   = next_clamp ? limit : req;
    next_len   = slots_needed(next_eff, wpp, fw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_planes <= '0;
      bpl_len    <= '0;
      clamped    <= 1'b0;
    end else if (load) begin
      eff_planes <= PL_W'(next_eff);
      bpl_len    <= LEN_W'(next_len);
      clamped    <= next_clamp;
    end
  end

endmodule

// File: rtl/dma_slot_decode.sv
module dma_slot_decode
  import dma_sched_pkg::*;
#(
  parameter int unsigned SLOT_W       = 8,
  parameter int unsigned PL_W         = 4,
  parameter int unsigned PI_W         = 3,
  parameter int unsigned LEN_W        = 8,
  parameter int unsigned NUM_SLOTS    = 228,
  parameter int unsigned DISK_SLOTS   = 3,
  parameter int unsigned AUDIO_SLOTS  = 4,
  parameter int unsigned SPRITE_SLOTS = 16
) (
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [PL_W-1:0]   eff_planes,
  input  logic [LEN_W-1:0]  bpl_len,
  input  logic              copr_req,
  input  logic              cpu_req,
  output owner_e            owner,
  output logic [PI_W-1:0]   plane,
  output logic              in_fixed,
  output logic              in_bpl
);

  localparam int unsigned AUD_BASE = DISK_SLOTS;
  localparam int unsigned SPR_BASE = AUD_BASE + AUDIO_SLOTS;
  localparam int unsigned BPL_BASE = SPR_BASE + SPRITE_SLOTS;

  int unsigned s;
  int unsigned bpl_end;
  int unsigned ofs;

  always_comb begin
    s        = 32'(slot_idx);
    bpl_end  = BPL_BASE + 32'(bpl_len);
    ofs      = s - BPL_BASE;
    in_fixed = (s < BPL_BASE) && (s < NUM_SLOTS);
    in_bpl   = (s >= BPL_BASE) && (s < bpl_end) && (s < NUM_SLOTS);
    owner    = OWN_NONE;
    plane    = '0;
    if (s >= NUM_SLOTS) begin
      owner = OWN_NONE;
    end else if (s < AUD_BASE) begin
      owner = OWN_DISK;
    end else if (s < SPR_BASE) begin
      owner = OWN_AUDIO;
    end else if (s < BPL_BASE) begin
      owner = OWN_SPRITE;
    end else if (in_bpl) begin
      owner = OWN_BPL;
      plane = PI_W'(plane_of(ofs, 32'(eff_planes)));
    end else if (copr_req) begin
      owner = OWN_COPR;
    end else if (cpu_req) begin
      owner = OWN_CPU;
    end
  end

endmodule

// File: rtl/dma_grant_reg.sv
module dma_grant_reg
  import dma_sched_pkg::*;
#(
  parameter int unsigned PI_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  owner_e             owner,
  input  logic [PI_W-1:0]    plane,
  output logic [NUM_REQ-1:0] grant,
  output logic [PI_W-1:0]    plane_idx
);

  logic [NUM_REQ-1:0] hit;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_hit
    assign hit[g] = (owner == owner_e'(g + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= '0;
      plane_idx <= '0;
    end else begin
      grant     <= hit;
      plane_idx <= (owner == OWN_BPL) ? plane : '0;
    end
  end

endmodule

// File: rtl/dma_slot_sched.sv
module dma_slot_sched
  import dma_sched_pkg::*;
#(
  parameter int unsigned SLOT_W       = 8,
  parameter int unsigned NUM_SLOTS    = 228,
  parameter int unsigned REQ_W        = 4,
  parameter int unsigned MAX_PLANES   = 8,
  parameter int unsigned BPL_BUDGET   = 80,
  parameter int unsigned DISK_SLOTS   = 3,
  parameter int unsigned AUDIO_SLOTS  = 4,
  parameter int unsigned SPRITE_SLOTS = 16,
  parameter int unsigned LO_WPP       = 8,
  parameter int unsigned HI_WPP       = 20,
  parameter int unsigned SHI_WPP      = 40,
  localparam int unsigned PL_W        = $clog2(MAX_PLANES + 1),
  localparam int unsigned PI_W        = $clog2(MAX_PLANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SLOT_W-1:0]  slot_idx,
  input  logic [1:0]         cfg_res,
  input  logic [REQ_W-1:0]   cfg_planes,
  input  logic [1:0]         cfg_fetch,
  input  logic               copr_req,
  input  logic               cpu_req,
  output logic [NUM_REQ-1:0] grant,
  output logic [PI_W-1:0]    plane_idx,
  output logic [PL_W-1:0]    eff_planes,
  output logic               clamped
);

  localparam int unsigned LEN_W = SLOT_W;

  logic             line_start;
  logic [LEN_W-1:0] bpl_len;
  owner_e           owner;
  logic [PI_W-1:0]  plane;
  logic             in_fixed;
  logic             in_bpl;

  assign line_start = (slot_idx == '0);

  dma_cfg_latch #(
    .REQ_W(REQ_W), .PL_W(PL_W), .LEN_W(LEN_W), .MAX_PLANES(MAX_PLANES),
    .BPL_BUDGET(BPL_BUDGET), .LO_WPP(LO_WPP), .HI_WPP(HI_WPP), .SHI_WPP(SHI_WPP)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .load(line_start),
    .res(cfg_res), .planes_req(cfg_planes), .fetch(cfg_fetch),
    .eff_planes(eff_planes), .bpl_len(bpl_len), .clamped(clamped)
  );

  dma_slot_decode #(
    .SLOT_W(SLOT_W), .PL_W(PL_W), .PI_W(PI_W), .LEN_W(LEN_W),
    .NUM_SLOTS(NUM_SLOTS), .DISK_SLOTS(DISK_SLOTS),
    .AUDIO_SLOTS(AUDIO_SLOTS), .SPRITE_SLOTS(SPRITE_SLOTS)
  ) i_dec (
    .slot_idx(slot_idx), .eff_planes(eff_planes), .bpl_len(bpl_len),
    .copr_req(copr_req), .cpu_req(cpu_req),
    .owner(owner), .plane(plane), .in_fixed(in_fixed), .in_bpl(in_bpl)
  );

  dma_grant_reg #(.PI_W(PI_W)) i_grant (
    .clk(clk), .rst_n(rst_n), .owner(owner), .plane(plane),
    .grant(grant), .plane_idx(plane_idx)
  );

endmodule

// File: rtl/dma_slot_sched_chk.sv
module dma_slot_sched_chk #(
  parameter int unsigned SLOT_W       = 8,
  parameter int unsigned PL_W         = 4,
  parameter int unsigned PI_W         = 3,
  parameter int unsigned NUM_SLOTS    = 228,
  parameter int unsigned DISK_SLOTS   = 3,
  parameter int unsigned AUDIO_SLOTS  = 4,
  parameter int unsigned SPRITE_SLOTS = 16,
  parameter int unsigned MAX_PLANES   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              copr_req,
  input logic [5:0]        grant,
  input logic [PI_W-1:0]   plane_idx,
  input logic [PL_W-1:0]   eff_planes,
  input logic              clamped,
  input logic              in_fixed,
  input logic              in_bpl
);

  localparam int unsigned SPR_BASE = DISK_SLOTS + AUDIO_SLOTS;
  localparam int unsigned BPL_BASE = SPR_BASE + SPRITE_SLOTS;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_disk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(slot_idx) < SLOT_W'(DISK_SLOTS)) |-> grant == 6'b000001);

  a_r3_audio: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(slot_idx) >= SLOT_W'(DISK_SLOTS)) && ($past(slot_idx) < SLOT_W'(SPR_BASE))
    |-> grant == 6'b000010);

  a_r3_sprite: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(slot_idx) >= SLOT_W'(SPR_BASE)) && ($past(slot_idx) < SLOT_W'(BPL_BASE))
    |-> grant == 6'b000100);

  a_r3_fixed_taken: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_fixed) |-> grant[2:0] != 3'b000);

  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_bpl) |-> grant == 6'b001000);

  a_r5_plane_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !grant[3] |-> plane_idx == '0);

  a_r5_plane_range: assert property (@(posedge clk) disable iff (!rst_n)
    grant[3] |-> PL_W'(plane_idx) < eff_planes);

  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    eff_planes <= PL_W'(MAX_PLANES));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(slot_idx) != '0) |-> $stable(eff_planes) && $stable(clamped));

  a_r9_copr_first: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(copr_req) |-> !grant[5]);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(slot_idx) >= SLOT_W'(NUM_SLOTS)) |-> grant == '0);

endmodule

bind dma_slot_sched dma_slot_sched_chk #(
  .SLOT_W(SLOT_W), .PL_W(PL_W), .PI_W(PI_W), .NUM_SLOTS(NUM_SLOTS),
  .DISK_SLOTS(DISK_SLOTS), .AUDIO_SLOTS(AUDIO_SLOTS),
  .SPRITE_SLOTS(SPRITE_SLOTS), .MAX_PLANES(MAX_PLANES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .copr_req(copr_req),
  .grant(grant), .plane_idx(plane_idx), .eff_planes(eff_planes),
  .clamped(clamped), .in_fixed(in_fixed), .in_bpl(in_bpl)
);

// File: tb/test_dma_slot_sched.sv
module test_dma_slot_sched;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] slot_idx = '0;
  logic [1:0] cfg_res = '0;
  logic [3:0] cfg_planes = '0;
  logic [1:0] cfg_fetch = '0;
  logic       copr_req = 1'b0;
  logic       cpu_req = 1'b0;
  logic [5:0] grant;
  logic [2:0] plane_idx;
  logic [3:0] eff_planes;
  logic       clamped;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_slot_sched i_dma_slot_sched (
    .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .cfg_res(cfg_res),
    .cfg_planes(cfg_planes), .cfg_fetch(cfg_fetch), .copr_req(copr_req),
    .cpu_req(cpu_req), .grant(grant), .plane_idx(plane_idx),
    .eff_planes(eff_planes), .clamped(clamped)
  );

  localparam logic [5:0] GD = 6'b000001;
  localparam logic [5:0] GA = 6'b000010;
  localparam logic [5:0] GS = 6'b000100;
  localparam logic [5:0] GB = 6'b001000;
  localparam logic [5:0] GC = 6'b010000;
  localparam logic [5:0] GU = 6'b100000;
  localparam logic [5:0] GN = 6'b000000;

  typedef struct packed {
    logic [3:0] rq;
    logic [1:0] res;
    logic [3:0] pl;
    logic [1:0] fw;
    logic [7:0] slot;
    logic       copr;
    logic       cpu;
    logic [5:0] g;
    logic [2:0] pi;
    logic [3:0] eff;
    logic       clamp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  2'd0, 4'd5,  2'd0, 8'd1,   1'b1, 1'b1, GD, 3'd0, 4'd5, 1'b0}, // R2 disk ignores requests
    '{4'd3,  2'd0, 4'd5,  2'd0, 8'd5,   1'b1, 1'b1, GA, 3'd0, 4'd5, 1'b0}, // R3 sound
    '{4'd3,  2'd0, 4'd5,  2'd0, 8'd22,  1'b0, 1'b0, GS, 3'd0, 4'd5, 1'b0}, // R3 last sprite slot
    '{4'd4,  2'd0, 4'd5,  2'd0, 8'd23,  1'b1, 1'b0, GB, 3'd0, 4'd5, 1'b0}, // R4 first window slot beats coprocessor
    '{4'd5,  2'd0, 4'd5,  2'd0, 8'd30,  1'b0, 1'b0, GB, 3'd2, 4'd5, 1'b0}, // R5 rotation 7 mod 5
    '{4'd4,  2'd0, 4'd5,  2'd0, 8'd62,  1'b0, 1'b0, GB, 3'd4, 4'd5, 1'b0}, // R4 last of 40 slots
    '{4'd9,  2'd0, 4'd5,  2'd0, 8'd63,  1'b1, 1'b1, GC, 3'd0, 4'd5, 1'b0}, // R9 coprocessor over CPU
    '{4'd9,  2'd0, 4'd5,  2'd0, 8'd63,  1'b0, 1'b1, GU, 3'd0, 4'd5, 1'b0}, // R9 CPU
    '{4'd9,  2'd0, 4'd5,  2'd0, 8'd63,  1'b0, 1'b0, GN, 3'd0, 4'd5, 1'b0}, // R9 idle
    '{4'd4,  2'd1, 4'd4,  2'd0, 8'd102, 1'b0, 1'b0, GB, 3'd3, 4'd4, 1'b0}, // R4 high 4 planes fills budget
    '{4'd4,  2'd1, 4'd4,  2'd0, 8'd103, 1'b0, 1'b1, GU, 3'd0, 4'd4, 1'b0}, // R4 first slot after window
    '{4'd7,  2'd1, 4'd6,  2'd0, 8'd103, 1'b0, 1'b1, GU, 3'd0, 4'd4, 1'b1}, // R7 high clamps to 4
    '{4'd7,  2'd2, 4'd3,  2'd0, 8'd102, 1'b0, 1'b0, GB, 3'd1, 4'd2, 1'b1}, // R7 super-high clamps to 2
    '{4'd6,  2'd1, 4'd5,  2'd1, 8'd72,  1'b0, 1'b0, GB, 3'd4, 4'd5, 1'b0}, // R6 code 1: 50 slots
    '{4'd6,  2'd1, 4'd5,  2'd1, 8'd73,  1'b1, 1'b0, GC, 3'd0, 4'd5, 1'b0}, // R6 code 1 window end
    '{4'd6,  2'd0, 4'd5,  2'd3, 8'd32,  1'b0, 1'b0, GB, 3'd4, 4'd5, 1'b0}, // R6 code 3: 10 slots
    '{4'd6,  2'd0, 4'd5,  2'd3, 8'd33,  1'b0, 1'b1, GU, 3'd0, 4'd5, 1'b0}, // R6 code 3 window end
    '{4'd6,  2'd0, 4'd5,  2'd2, 8'd62,  1'b0, 1'b0, GB, 3'd4, 4'd5, 1'b0}, // R6 reserved code acts as 0
    '{4'd4,  2'd0, 4'd0,  2'd0, 8'd23,  1'b1, 1'b0, GC, 3'd0, 4'd0, 1'b0}, // R4 empty window
    '{4'd7,  2'd0, 4'd12, 2'd0, 8'd86,  1'b0, 1'b0, GB, 3'd7, 4'd8, 1'b1}, // R7 request above 8
    '{4'd7,  2'd0, 4'd12, 2'd0, 8'd87,  1'b0, 1'b1, GU, 3'd0, 4'd8, 1'b1}, // R7 64-slot window end
    '{4'd10, 2'd0, 4'd5,  2'd0, 8'd230, 1'b1, 1'b1, GN, 3'd0, 4'd5, 1'b0}, // R10 past line end
    '{4'd4,  2'd3, 4'd2,  2'd0, 8'd102, 1'b0, 1'b0, GB, 3'd1, 4'd2, 1'b0}, // R4 res code 3 as super-high
    '{4'd7,  2'd2, 4'd8,  2'd3, 8'd102, 1'b0, 1'b0, GB, 3'd7, 4'd8, 1'b0}  // R7 super-high 8 planes at code 3
  };

  task automatic chk(input int rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic load_line(input logic [1:0] r, input logic [3:0] p, input logic [1:0] f);
    @(negedge clk);
    slot_idx = 8'd0; cfg_res = r; cfg_planes = p; cfg_fetch = f;
    copr_req = 1'b0; cpu_req = 1'b0;
  endtask

  task automatic present(input logic [7:0] s, input logic c, input logic u);
    @(negedge clk);
    slot_idx = s; copr_req = c; cpu_req = u;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(1, "grant in reset", int'(grant), 0);
    chk(1, "plane_idx in reset", int'(plane_idx), 0);
    chk(1, "eff_planes in reset", int'(eff_planes), 0);
    chk(1, "clamped in reset", int'(clamped), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      load_line(VEC[i].res, VEC[i].pl, VEC[i].fw);
      present(VEC[i].slot, VEC[i].copr, VEC[i].cpu);
      chk(int'(VEC[i].rq), $sformatf("vector %0d grant", i), int'(grant), int'(VEC[i].g));
      chk(int'(VEC[i].rq), $sformatf("vector %0d plane_idx", i), int'(plane_idx), int'(VEC[i].pi));
      chk(int'(VEC[i].rq), $sformatf("vector %0d eff_planes", i), int'(eff_planes), int'(VEC[i].eff));
      chk(int'(VEC[i].rq), $sformatf("vector %0d clamped", i), int'(clamped), int'(VEC[i].clamp));
    end

    // R8: configuration changed mid-line is not used before slot 0
    load_line(2'd0, 4'd5, 2'd0);
    present(8'd40, 1'b0, 1'b0);
    cfg_res = 2'd1; cfg_planes = 4'd6; cfg_fetch = 2'd0;
    present(8'd70, 1'b0, 1'b1);
    chk(8, "mid-line change grant", int'(grant), int'(GU));
    chk(8, "mid-line change eff_planes", int'(eff_planes), 5);
    chk(8, "mid-line change clamped", int'(clamped), 0);
    present(8'd0, 1'b0, 1'b0);
    present(8'd70, 1'b0, 1'b1);
    chk(8, "next line grant", int'(grant), int'(GB));
    chk(8, "next line plane_idx", int'(plane_idx), 3);
    chk(8, "next line eff_planes", int'(eff_planes), 4);
    chk(8, "next line clamped", int'(clamped), 1);

    // R11: grant follows the slot one edge later, steady between edges
    @(negedge clk);
    slot_idx = 8'd1; cpu_req = 1'b1;
    #2;
    chk(11, "grant before edge", int'(grant), int'(GB));
    @(negedge clk);
    chk(11, "grant after edge", int'(grant), int'(GD));

    // R1: reset during operation clears state
    rst_n = 1'b0;
    #2;
    chk(1, "grant after reset", int'(grant), 0);
    chk(1, "eff_planes after reset", int'(eff_planes), 0);
    chk(1, "clamped after reset", int'(clamped), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule